// File: doc/BRIEF.md
# Masked Address Chip-Select Decoder

This block turns a 20-bit external bus address into a set of chip-select lines, one per channel. Each channel holds a 12-bit base value, a 12-bit mask value and an enable flag. The compare covers only address bits 19 down to 8, so a channel selects a naturally aligned window whose size is a power of two between 256 bytes and the whole 1 MB space. A window of 2^k bytes needs a mask with its upper 20 − k bits set and the rest clear. For example, base 0800H with mask 0800H covers 80000H–FFFFFH. Base 07E0H with mask 0FE0H covers 7E000H–7FFFFH. Base 001EH with mask 0FFFH covers the single granule 01E00H–01EFFH.

Software loads the channel values through a small synchronous write port and reads them back through a combinational read path. On each clock where the address-valid strobe is high, the decoder compares the address against every enabled channel. When several channels hit, only the lowest-numbered one is granted. The result is registered, so the selects appear in the clock after the strobe and hold for one cycle.

Top module: `masked_cs_decoder`

## Requirements
- R1: An enabled channel hits when (addr[19:8] & mask) equals (base & mask), with register bit 11 lined up with address bit 19. Address bits 7:0 never affect the result.
- R2: Write-data bits 15:12 of a base or mask write are discarded, and those bits read back as zero.
- R3: When more than one channel hits, only the lowest-numbered hitting channel drives its select high.
- R4: A channel whose enable bit (bit 0 of its control field) is 0 never drives its select.
- R5: After reset, every base, mask and enable reads as zero and every select is low.
- R6: A select rises in the clock after a cycle with the strobe high. It reflects the address and registers of that strobe cycle. After a cycle with the strobe low, all selects are low.
- R7: A write with cfg_we high at a clock edge updates only the addressed field of the addressed channel. Field codes are 0 for base, 1 for mask and 2 for control. Field code 3 and channel numbers at or above the channel count are ignored, and both read back zero.
- R8: At most one select is high in any cycle.
- R9: A mask of zero on an enabled channel selects the whole 1 MB space.
- R10: The three example windows decode exactly over their ranges: 0800H/0800H over 80000H–FFFFFH, 001EH/0FFFH over 01E00H–01EFFH, and 07E0H/0FE0H over 7E000H–7FFFFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_chan | input | 2 | Channel number for a write or a read |
| cfg_field | input | 2 | Field code: 0 base, 1 mask, 2 control, 3 none |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for the selected channel and field |
| bus_addr | input | 20 | External bus address |
| bus_valid | input | 1 | Address-valid strobe |
| cs | output | 3 | Registered chip selects, one per channel |

## Verification
The hardest situation to reach is an overlap where several enabled channels hit the same address. A wrong priority shows up only there. It also stays hidden whenever the higher-numbered channel happens to cover a disjoint part of the space. The bench reaches it by setting channel 0 to a zero mask, which hits every address, on top of the three example windows. It then sweeps every 256-byte granule, disables channels one at a time, and repeats the sweep, so each pair of overlapping channels is met over its full range. Every sweep varies the low address byte, which confirms that bits 7:0 are ignored.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_NONE = 2'd3
    } cfg_field_e;

    localparam int unsigned REG_DATA_W = 16;
endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CMP_W  = 12,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              chan,
    input  logic [1:0]                    field,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_CH-1:0][CMP_W-1:0]  base_o,
    output logic [NUM_CH-1:0][CMP_W-1:0]  mask_o,
    output logic [NUM_CH-1:0]             en_o
);
    import mcs_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0][CMP_W-1:0] base;
        logic [NUM_CH-1:0][CMP_W-1:0] mask;
        logic [NUM_CH-1:0]            en;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (chan == IDX_W'(i)) begin
                if (we) begin
                    case (cfg_field_e'(field))
                        FLD_BASE: st_d.base[i] = wdata[CMP_W-1:0];
                        FLD_MASK: st_d.mask[i] = wdata[CMP_W-1:0];
                        FLD_CTRL: st_d.en[i]   = wdata[0];
                        default:  ;
                    endcase
                end
                case (cfg_field_e'(field))
                    FLD_BASE: rdata = DATA_W'(st_q.base[i]);
                    FLD_MASK: rdata = DATA_W'(st_q.mask[i]);
                    FLD_CTRL: rdata = DATA_W'(st_q.en[i]);
                    default:  rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;
    assign mask_o = st_q.mask;
    assign en_o   = st_q.en;

    // R7: a base write lands in the addressed channel only
    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_wchk
        assert_base_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (we && field == 2'd0 && chan == IDX_W'(g)) |=> base_o[g] == $past(wdata[CMP_W-1:0]));
        assert_base_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && field == 2'd0 && chan == IDX_W'(g)) |=> $stable(base_o[g]));
    end
endmodule

// File: rtl/mcs_match.sv
module mcs_match #(
    parameter int unsigned CMP_W = 12
) (
    input  logic [CMP_W-1:0] addr_hi,
    input  logic [CMP_W-1:0] base,
    input  logic [CMP_W-1:0] mask,
    input  logic             en,
    output logic             hit
);
    logic [CMP_W-1:0] diff;

    always_comb begin
        diff = (addr_hi ^ base) & mask;
        hit  = en && (diff == '0);
    end
endmodule

// File: rtl/mcs_prio.sv
module mcs_prio #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/masked_cs_decoder.sv
module masked_cs_decoder #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned GRAN_W = 8,
    parameter int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_chan,
    input  logic [1:0]                    cfg_field,
    input  logic [mcs_pkg::REG_DATA_W-1:0] cfg_wdata,
    output logic [mcs_pkg::REG_DATA_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_valid,
    output logic [NUM_CH-1:0]             cs
);
    localparam int unsigned CMP_W  = ADDR_W - GRAN_W;
    localparam int unsigned DATA_W = mcs_pkg::REG_DATA_W;

    logic [NUM_CH-1:0][CMP_W-1:0] base, mask;
    logic [NUM_CH-1:0]            en, hit, grant;
    logic [CMP_W-1:0]             addr_hi;

    typedef struct packed {
        logic [NUM_CH-1:0] cs;
    } out_t;

    out_t st_d, st_q;

    assign addr_hi = bus_addr[ADDR_W-1:GRAN_W];

    mcs_cfg_regs #(
        .NUM_CH(NUM_CH), .CMP_W(CMP_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .chan(cfg_chan),
        .field(cfg_field), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .base_o(base), .mask_o(mask), .en_o(en)
    );

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        mcs_match #(.CMP_W(CMP_W)) u_match (
            .addr_hi(addr_hi), .base(base[g]), .mask(mask[g]),
            .en(en[g]), .hit(hit[g])
        );
    end

    mcs_prio #(.N(NUM_CH)) u_prio (.req(hit), .grant(grant));

    always_comb begin
        st_d    = st_q;
        st_d.cs = bus_valid ? grant : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs = st_q.cs;

    assert_single_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> cs == '0);

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_chk
        assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |=> !cs[g]);
        assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && hit[g]) |=> (cs[g] || ((cs & NUM_CH'((1 << g) - 1)) != '0)));
        assert_hit_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && en[g] && ((addr_hi & mask[g]) == (base[g] & mask[g])))
                |=> cs != '0);
    end
endmodule

// File: tb/tb_masked_cs_decoder.sv
module tb_masked_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_chan = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [19:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic [2:0]  cs;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [11:0] m_base [3];
    logic [11:0] m_mask [3];
    logic        m_en   [3];

    masked_cs_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_addr(bus_addr), .bus_valid(bus_valid), .cs(cs)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(logic [19:0] a);
        logic [2:0] r = '0;
        for (int i = 0; i < 3; i++)
            if (r == '0 && m_en[i] && ((a[19:8] & m_mask[i]) == (m_base[i] & m_mask[i])))
                r[i] = 1'b1;
        return r;
    endfunction

    task automatic wr(int ch, int fld, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_field = 2'(fld); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ch < 3) begin
            if (fld == 0) m_base[ch] = d[11:0];
            if (fld == 1) m_mask[ch] = d[11:0];
            if (fld == 2) m_en[ch]   = d[0];
        end
    endtask

    task automatic rd(int ch, int fld, logic [15:0] exp, string req);
        cfg_chan = 2'(ch); cfg_field = 2'(fld);
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic strobe(logic [19:0] a, string req);
        @(negedge clk);
        bus_addr = a; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(req, 16'(cs), 16'(model(a)));
    endtask

    task automatic sweep(string req);
        for (int g = 0; g < 4096; g++)
            strobe({12'(g), 8'((g * 37 + 11) % 256)}, req);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_mask[i] = '0; m_en[i] = 1'b0; end
        #23; rst_n = 1'b1;
        // R5: reset state
        @(negedge clk);
        chk("R5 cs", 16'(cs), 16'h0);
        for (int i = 0; i < 3; i++)
            for (int f = 0; f < 3; f++) rd(i, f, 16'h0, "R5 regs");
        // R4: all disabled after reset, nothing decodes
        strobe(20'h00000, "R4");
        strobe(20'hFFFFF, "R4");
        // R2 / R7: upper bits dropped, field 3 and channel 3 ignored
        wr(0, 0, 16'hF800); rd(0, 0, 16'h0800, "R2 base");
        wr(0, 1, 16'hA800); rd(0, 1, 16'h0800, "R2 mask");
        wr(1, 0, 16'h001E); wr(1, 1, 16'h0FFF);
        wr(2, 0, 16'h07E0); wr(2, 1, 16'h0FE0);
        rd(1, 0, 16'h001E, "R7"); rd(2, 1, 16'h0FE0, "R7"); rd(0, 0, 16'h0800, "R7");
        wr(1, 3, 16'hFFFF); rd(1, 3, 16'h0, "R7 field3");
        rd(1, 0, 16'h001E, "R7 field3 no effect"); rd(1, 1, 16'h0FFF, "R7 field3 no effect");
        wr(3, 0, 16'h0123); rd(3, 0, 16'h0, "R7 chan3");
        rd(0, 0, 16'h0800, "R7 chan3 no effect");
        rd(0, 2, 16'h0, "R4 still disabled");
        strobe(20'h80000, "R4 disabled");
        // enable all three example windows
        wr(0, 2, 16'h0001); wr(1, 2, 16'h0001); wr(2, 2, 16'h0001);
        rd(2, 2, 16'h0001, "R7 ctrl");
        // R10: window edges
        strobe(20'h7FFFF, "R10"); strobe(20'h80000, "R10"); strobe(20'hFFFFF, "R10");
        strobe(20'h01DFF, "R10"); strobe(20'h01E00, "R10"); strobe(20'h01EFF, "R10");
        strobe(20'h01F00, "R10"); strobe(20'h7DFFF, "R10"); strobe(20'h7E000, "R10");
        chk("R10 expect ch2", 16'(model(20'h7E000)), 16'h4);
        // R1: full sweep, low byte varied
        sweep("R1");
        // R6: strobe low gives no select even for a hitting address
        @(negedge clk); bus_addr = 20'h90000; bus_valid = 1'b0;
        @(negedge clk); chk("R6 idle", 16'(cs), 16'h0);
        // R6: one-cycle pulse
        @(negedge clk); bus_valid = 1'b1;
        @(negedge clk); bus_valid = 1'b0; chk("R6 pulse", 16'(cs), 16'h1);
        @(negedge clk); chk("R6 drop", 16'(cs), 16'h0);
        // R9 / R3: channel 0 mask zero overlaps everything
        wr(0, 1, 16'h0000);
        strobe(20'h01E40, "R9"); strobe(20'h7E123, "R3");
        sweep("R3 R9");
        // R3: channel 0 off, 1 and 2 overlap over 1E00 region
        wr(0, 2, 16'h0000);
        wr(2, 0, 16'h0000); wr(2, 1, 16'h0000);
        strobe(20'h01E55, "R3"); strobe(20'h33333, "R3");
        sweep("R3");
        // R4: disable channel 2, only channel 1 window remains
        wr(2, 2, 16'h0000);
        strobe(20'h33333, "R4"); strobe(20'h01E00, "R4");
        // R8: every sweep above compared the whole cs vector against a one-hot model
        chk("R8", 16'($countones(model(20'h01E00))), 16'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule